// File: doc/BRIEF.md
# Tiled Surface Address Generator

This block turns a start coordinate inside a block-tiled surface into the values a copy datapath needs before it can walk that surface. The caller supplies the tile-mode word, the surface width and height in pixels, the bytes per pixel, the start coordinate (x, y, z) and a 40-bit base address, then pulses start. The block returns four results: the adjusted 40-bit start address, a pitch measured in whole tile rows, a Y-tile descriptor and a YZ tile-size word.

The surface is cut into tiles that are 2^Tp bytes wide, 2^Th rows tall and 2^Td slices deep. The byte offset of the start pixel is the tile's linear index scaled by the tile volume, plus the position inside the tile. The tile counts per row and per column are rounded up. The five products the formula needs (x·cpp, w·cpp, nTy·nTx, Ty·nTx and Tz·nTy·nTx) run one after another on a single shared shift-and-add multiplier. The latency therefore depends on the operand values, and a one-cycle done pulse marks completion.

Top module: `tile_addr_gen`

## Requirements
- R1: After reset, busy_o and done_o are low and addr_o, pitch_o, ytile_o and yzsize_o are all zero.
- R2: The tile-mode word holds three shift amounts: Tp in bits [3:0], Th in bits [7:4] and Td in bits [11:8]. Ts is Tp+Th+Td.
- R3: addr_o equals base + ((Tz·nTy·nTx + Ty·nTx + Tx) << Ts) + (Tzo << (Tp+Th)) + (Tyo << Tp) + Txo. Here Tx and Txo are the quotient and remainder of x·cpp by 2^Tp, Ty and Tyo are those of y by 2^Th, and Tz and Tzo are those of z by 2^Td.
- R4: The tile counts are rounded up: nTx = (w·cpp + 2^Tp − 1) >> Tp and nTy = (h + 2^Th − 1) >> Th.
- R5: pitch_o equals the low 32 bits of (nTx − 1) << Ts.
- R6: ytile_o equals (2^Th << 12) | (2^Th − Tyo), taken to 32 bits.
- R7: yzsize_o equals (2^Th >> 2) << Td, so Th below 2 gives zero.
- R8: A start pulse that arrives while busy_o is high is ignored. The running job's inputs and results are unchanged.
- R9: busy_o is high from the cycle after an accepted start until the result is ready. done_o is then high for exactly one cycle with busy_o low. The outputs change only together with that pulse and hold their values between pulses.
- R10: The address sum wraps modulo 2^40, so a carry out of the low 32 bits lands in addr_o[39:32].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a computation with the present inputs |
| tile_mode_i | input | 12 | Tile shift fields Tp, Th, Td |
| width_i | input | 19 | Surface width in pixels |
| height_i | input | 13 | Surface height in rows |
| cpp_i | input | 5 | Bytes per pixel |
| x_i | input | 19 | Start column in pixels |
| y_i | input | 13 | Start row |
| z_i | input | 12 | Start slice |
| base_i | input | 40 | Surface base address |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result-ready pulse |
| addr_o | output | 40 | Adjusted start address |
| pitch_o | output | 32 | Pitch in tile units |
| ytile_o | output | 32 | Y-tile descriptor |
| yzsize_o | output | 32 | YZ tile size |

## Verification
The assertions check the protocol properties on every cycle: done lasts a single cycle and is never high together with busy, the results stay stable outside the finishing step, the latched job stays stable when start arrives during a run, and the multiplier is never launched while it is still working. The arithmetic is shown only by the bench's scenarios, which compare each result with a behavioural model. The scenarios cover zero shift fields, rounding at exact and inexact tile multiples, Th below 2, a wrap past 2^40 and full-range shift fields.

// File: rtl/tsag_pkg.sv
package tsag_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_XC,
      ST_WC,
      ST_NN,
      ST_TY,
      ST_TZ,
      ST_FIN
   } seq_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/tsag_decode.sv
module tsag_decode #(
   parameter int unsigned AW  = 40,
   parameter int unsigned SHW = 4,
   localparam int unsigned TMW = 3 * SHW,
   localparam int unsigned TSW = SHW + 2
) (
   input  logic [TMW-1:0] tm_i,
   output logic [SHW-1:0] tp_o,
   output logic [SHW-1:0] th_o,
   output logic [SHW-1:0] td_o,
   output logic [TSW-1:0] tph_o,
   output logic [TSW-1:0] ts_o,
   output logic [AW-1:0]  mask_p_o,
   output logic [AW-1:0]  mask_h_o,
   output logic [AW-1:0]  mask_d_o
);

   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   always_comb begin
      tp_o     = tm_i[SHW-1:0];
      th_o     = tm_i[2*SHW-1:SHW];
      td_o     = tm_i[3*SHW-1:2*SHW];
      tph_o    = TSW'(tp_o) + TSW'(th_o);
      ts_o     = tph_o + TSW'(td_o);
      mask_p_o = (ONE << tp_o) - ONE;
      mask_h_o = (ONE << th_o) - ONE;
      mask_d_o = (ONE << td_o) - ONE;
   end

endmodule

// File: rtl/tsag_mul.sv
module tsag_mul #(
   parameter int unsigned AW   = 40,
   parameter int unsigned MBW  = 13,
   parameter int unsigned STEP = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [AW-1:0]  a_i,
   input  logic [MBW-1:0] b_i,
   output logic           busy_o,
   output logic           done_o,
   output logic [AW-1:0]  prod_o
);

   logic [AW-1:0]  acc_q, a_q, acc_n, a_n;
   logic [MBW-1:0] b_q, b_n;
   logic           run_q;

   initial begin
      assert (STEP == 1 || STEP == 2) else $error("tsag_mul: STEP must be 1 or 2");
      assert (MBW >= 2) else $error("tsag_mul: MBW too small");
   end

   generate
      if (STEP == 2) begin : g_radix4
         always_comb begin
            acc_n = acc_q + (b_q[0] ? a_q : '0) + (b_q[1] ? (a_q << 1) : '0);
            a_n   = a_q << 2;
            b_n   = b_q >> 2;
         end
      end else begin : g_radix2
         always_comb begin
            acc_n = acc_q + (b_q[0] ? a_q : '0);
            a_n   = a_q << 1;
            b_n   = b_q >> 1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         run_q  <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && !run_q) begin
            acc_q <= '0;
            a_q   <= a_i;
            b_q   <= b_i;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (b_q == '0) begin
               run_q  <= 1'b0;
               done_o <= 1'b1;
            end else begin
               acc_q <= acc_n;
               a_q   <= a_n;
               b_q   <= b_n;
            end
         end
      end
   end

   assign busy_o = run_q;
   assign prod_o = acc_q;

   // R3
   mul_done_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(run_q) && !run_q);

endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen #(
   parameter int unsigned AW   = 40,
   parameter int unsigned OW   = 32,
   parameter int unsigned SHW  = 4,
   parameter int unsigned XW   = 19,
   parameter int unsigned YW   = 13,
   parameter int unsigned ZW   = 12,
   parameter int unsigned CW   = 5,
   parameter int unsigned STEP = 1,
   localparam int unsigned TMW = 3 * SHW,
   localparam int unsigned TSW = SHW + 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [TMW-1:0] tile_mode_i,
   input  logic [XW-1:0]  width_i,
   input  logic [YW-1:0]  height_i,
   input  logic [CW-1:0]  cpp_i,
   input  logic [XW-1:0]  x_i,
   input  logic [YW-1:0]  y_i,
   input  logic [ZW-1:0]  z_i,
   input  logic [AW-1:0]  base_i,
   output logic           busy_o,
   output logic           done_o,
   output logic [AW-1:0]  addr_o,
   output logic [OW-1:0]  pitch_o,
   output logic [OW-1:0]  ytile_o,
   output logic [OW-1:0]  yzsize_o
);
   import tsag_pkg::*;

   localparam int unsigned MBW    = max3(CW, YW, ZW);
   localparam int unsigned YT_POS = 12;
   localparam logic [OW-1:0] ONE_O = {{(OW-1){1'b0}}, 1'b1};

   initial begin
      assert (AW >= OW) else $error("tile_addr_gen: AW must cover OW");
      assert (OW > YT_POS + 1) else $error("tile_addr_gen: OW too narrow for descriptor");
      assert (XW + CW < AW) else $error("tile_addr_gen: x*cpp exceeds AW");
   end

   seq_state_t     state_q;
   logic           kick_q;
   logic [TMW-1:0] tm_q;
   logic [XW-1:0]  w_q, x_q;
   logic [YW-1:0]  h_q, y_q;
   logic [ZW-1:0]  z_q;
   logic [CW-1:0]  cpp_q;
   logic [AW-1:0]  base_q;
   logic [AW-1:0]  xc_q, wc_q, nn_q, tyn_q, tzn_q;

   logic [SHW-1:0] tp, th, td;
   logic [TSW-1:0] tph, ts;
   logic [AW-1:0]  mask_p, mask_h, mask_d;

   logic [AW-1:0]  ntx, nty, tx, txo;
   logic [YW-1:0]  ty, tyo;
   logic [ZW-1:0]  tz, tzo;
   logic [AW-1:0]  offset, pitch_full;
   logic [OW-1:0]  th_pow, ytile_n, yz_n;

   logic [AW-1:0]  m_a, m_prod;
   logic [MBW-1:0] m_b;
   logic           m_busy, m_done;

   tsag_decode #(.AW(AW), .SHW(SHW)) u_decode (
      .tm_i     (tm_q),
      .tp_o     (tp),
      .th_o     (th),
      .td_o     (td),
      .tph_o    (tph),
      .ts_o     (ts),
      .mask_p_o (mask_p),
      .mask_h_o (mask_h),
      .mask_d_o (mask_d)
   );

   tsag_mul #(.AW(AW), .MBW(MBW), .STEP(STEP)) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (kick_q),
      .a_i     (m_a),
      .b_i     (m_b),
      .busy_o  (m_busy),
      .done_o  (m_done),
      .prod_o  (m_prod)
   );

   // tile counts, tile indices and intra-tile remainders
   always_comb begin
      ntx    = (wc_q + mask_p) >> tp;
      nty    = (AW'(h_q) + mask_h) >> th;
      tx     = xc_q >> tp;
      txo    = xc_q & mask_p;
      ty     = y_q >> th;
      tyo    = y_q & YW'(mask_h);
      tz     = z_q >> td;
      tzo    = z_q & ZW'(mask_d);
      offset = ((tzn_q + tyn_q + tx) << ts)
             + (AW'(tzo) << tph)
             + (AW'(tyo) << tp)
             + txo;
      pitch_full = (ntx - AW'(1)) << ts;
      th_pow  = ONE_O << th;
      ytile_n = (th_pow << YT_POS) | (th_pow - OW'(tyo));
      yz_n    = (th_pow >> 2) << td;
   end

   // operand selection for the shared multiplier
   always_comb begin
      m_a = '0;
      m_b = '0;
      unique case (state_q)
         ST_XC: begin m_a = AW'(x_q); m_b = MBW'(cpp_q); end
         ST_WC: begin m_a = AW'(w_q); m_b = MBW'(cpp_q); end
         ST_NN: begin m_a = ntx;      m_b = MBW'(nty);   end
         ST_TY: begin m_a = ntx;      m_b = MBW'(ty);    end
         ST_TZ: begin m_a = nn_q;     m_b = MBW'(tz);    end
         default: begin m_a = '0;     m_b = '0;          end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         kick_q   <= 1'b0;
         done_o   <= 1'b0;
         tm_q     <= '0;
         w_q      <= '0;
         x_q      <= '0;
         h_q      <= '0;
         y_q      <= '0;
         z_q      <= '0;
         cpp_q    <= '0;
         base_q   <= '0;
         xc_q     <= '0;
         wc_q     <= '0;
         nn_q     <= '0;
         tyn_q    <= '0;
         tzn_q    <= '0;
         addr_o   <= '0;
         pitch_o  <= '0;
         ytile_o  <= '0;
         yzsize_o <= '0;
      end else begin
         done_o <= 1'b0;
         kick_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               tm_q    <= tile_mode_i;
               w_q     <= width_i;
               h_q     <= height_i;
               cpp_q   <= cpp_i;
               x_q     <= x_i;
               y_q     <= y_i;
               z_q     <= z_i;
               base_q  <= base_i;
               kick_q  <= 1'b1;
               state_q <= ST_XC;
            end
            ST_XC: if (m_done) begin
               xc_q    <= m_prod;
               kick_q  <= 1'b1;
               state_q <= ST_WC;
            end
            ST_WC: if (m_done) begin
               wc_q    <= m_prod;
               kick_q  <= 1'b1;
               state_q <= ST_NN;
            end
            ST_NN: if (m_done) begin
               nn_q    <= m_prod;
               kick_q  <= 1'b1;
               state_q <= ST_TY;
            end
            ST_TY: if (m_done) begin
               tyn_q   <= m_prod;
               kick_q  <= 1'b1;
               state_q <= ST_TZ;
            end
            ST_TZ: if (m_done) begin
               tzn_q   <= m_prod;
               state_q <= ST_FIN;
            end
            ST_FIN: begin
               addr_o   <= base_q + offset;
               pitch_o  <= pitch_full[OW-1:0];
               ytile_o  <= ytile_n;
               yzsize_o <= yz_n;
               done_o   <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);

   // R8
   ign_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(tm_q) && $stable(base_q) && $stable(x_q));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_FIN) |=> $stable(addr_o) && $stable(pitch_o)
                              && $stable(ytile_o) && $stable(yzsize_o));

   // R3
   mul_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_q |-> !m_busy);

endmodule

// File: tb/tile_addr_gen_tb.sv
module tile_addr_gen_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [11:0] tile_mode_i = '0;
   logic [18:0] width_i = '0;
   logic [12:0] height_i = '0;
   logic [4:0]  cpp_i = '0;
   logic [18:0] x_i = '0;
   logic [12:0] y_i = '0;
   logic [11:0] z_i = '0;
   logic [39:0] base_i = '0;
   logic        busy_o, done_o;
   logic [39:0] addr_o;
   logic [31:0] pitch_o, ytile_o, yzsize_o;

   int total = 0;
   int bad = 0;

   bit          pending = 0;
   bit          have_last = 0;
   longint unsigned e_addr, e_pitch, e_ytile, e_yz;
   longint unsigned l_addr, l_pitch, l_ytile, l_yz;
   string       job_tag;

   localparam longint unsigned M40 = 64'h0000_00FF_FFFF_FFFF;
   localparam longint unsigned M32 = 64'h0000_0000_FFFF_FFFF;

   always #5 clk = ~clk;

   tile_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tile_mode_i(tile_mode_i),
      .width_i(width_i), .height_i(height_i), .cpp_i(cpp_i), .x_i(x_i),
      .y_i(y_i), .z_i(z_i), .base_i(base_i), .busy_o(busy_o), .done_o(done_o),
      .addr_o(addr_o), .pitch_o(pitch_o), .ytile_o(ytile_o), .yzsize_o(yzsize_o)
   );

   task automatic chk(input bit ok, input string req, input longint unsigned act,
                      input longint unsigned exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: act=0x%0h exp=0x%0h (%s) t=%0t", req, act, exp, job_tag, $time);
      end
   endtask

   // behavioural reference, straight from the requirement formulas
   task automatic model(input longint unsigned tm, w, h, cpp, x, y, z, base);
      longint unsigned tp, th, td, ts, xc, wc, ntx, nty, tx, txo, ty, tyo, tz, tzo, off;
      tp  = tm & 15;          // R2 Tp in bits [3:0]
      th  = (tm >> 4) & 15;   // R2 Th in bits [7:4]
      td  = (tm >> 8) & 15;   // R2 Td in bits [11:8]
      ts  = tp + th + td;
      xc  = x * cpp;
      wc  = w * cpp;
      ntx = (wc + (64'd1 << tp) - 1) >> tp;  // R4
      nty = (h + (64'd1 << th) - 1) >> th;   // R4
      tx  = xc >> tp;  txo = xc % (64'd1 << tp);
      ty  = y >> th;   tyo = y % (64'd1 << th);
      tz  = z >> td;   tzo = z % (64'd1 << td);
      off = ((tz * nty * ntx + ty * ntx + tx) << ts) + (tzo << (tp + th)) + (tyo << tp) + txo;
      e_addr  = (base + off) & M40;          // R10 wrap
      e_pitch = ((ntx - 1) << ts) & M32;
      e_ytile = (((64'd1 << th) << 12) | ((64'd1 << th) - tyo)) & M32;
      e_yz    = (((64'd1 << th) >> 2) << td) & M32;
   endtask

   // compare at each clock, 2 ns after the edge
   task automatic observe();
      if (done_o) begin
         chk(pending, "R9 done without job", 64'(done_o), 64'd0);
         chk(!busy_o, "R9 busy with done", 64'(busy_o), 64'd0);
         chk(64'(addr_o) == e_addr, "R3 addr", 64'(addr_o), e_addr);
         chk(64'(pitch_o) == e_pitch, "R5 pitch", 64'(pitch_o), e_pitch);
         chk(64'(ytile_o) == e_ytile, "R6 ytile", 64'(ytile_o), e_ytile);
         chk(64'(yzsize_o) == e_yz, "R7 yzsize", 64'(yzsize_o), e_yz);
         l_addr = e_addr; l_pitch = e_pitch; l_ytile = e_ytile; l_yz = e_yz;
         have_last = 1;
         pending = 0;
      end else begin
         chk(busy_o == pending, "R9 busy", 64'(busy_o), 64'(pending));
         if (have_last) begin
            chk(64'(addr_o) == l_addr && 64'(pitch_o) == l_pitch &&
                64'(ytile_o) == l_ytile && 64'(yzsize_o) == l_yz,
                "R9 hold", 64'(addr_o), l_addr);
         end
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
      observe();
   endtask

   task automatic set_in(input longint unsigned tm, w, h, cpp, x, y, z, base);
      tile_mode_i = 12'(tm); width_i = 19'(w); height_i = 13'(h); cpp_i = 5'(cpp);
      x_i = 19'(x); y_i = 13'(y); z_i = 12'(z); base_i = 40'(base);
   endtask

   task automatic run_job(input string tag, input longint unsigned tm, w, h, cpp,
                          x, y, z, base, input bit poke);
      job_tag = tag;
      set_in(tm, w, h, cpp, x, y, z, base);
      model(tm, w, h, cpp, x, y, z, base);
      pending = 1;
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
      for (int n = 0; n < 3000 && pending; n++) begin
         if (poke && n == 4) begin
            // R8: a second start with different inputs during the run
            set_in(tm ^ 12'h123, w + 7, h + 3, cpp + 1, x + 9, y + 5, z + 2, base + 64'h40);
            start_i = 1'b1;
            tick();
            start_i = 1'b0;
         end else begin
            tick();
         end
      end
      if (pending) begin
         chk(0, "R9 no done", 64'(busy_o), 64'd0);
         pending = 0;
      end
      tick();
   endtask

   initial begin : wd
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R9 watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      // R1 reset state
      chk(!busy_o && !done_o, "R1 ctrl", 64'({busy_o, done_o}), 64'd0);
      chk(addr_o == '0 && pitch_o == '0, "R1 addr/pitch", 64'(addr_o), 64'd0);
      chk(ytile_o == '0 && yzsize_o == '0, "R1 ytile/yz", 64'(ytile_o), 64'd0);
      tick();

      run_job("R2 zero shifts", 12'h000, 100, 50, 4, 3, 2, 1, 64'h1000, 0);
      run_job("R2 only Tp", 12'h006, 300, 77, 4, 37, 21, 0, 64'h2_0000_0000, 0);
      run_job("R2 only Th", 12'h040, 300, 77, 4, 37, 21, 0, 64'h2_0000_0000, 0);
      run_job("R2 only Td", 12'h300, 300, 77, 4, 37, 21, 13, 64'h2_0000_0000, 0);
      run_job("R3 all fields", 12'h235, 640, 480, 4, 123, 45, 13, 64'h12_3456_7000, 0);
      run_job("R4 exact multiple", 12'h036, 64, 24, 2, 5, 9, 0, 64'h0, 0);
      run_job("R4 one over", 12'h036, 65, 25, 2, 5, 9, 0, 64'h0, 0);
      run_job("R7 Th one", 12'h214, 50, 10, 1, 7, 3, 5, 64'h800, 0);
      run_job("R7 Th two", 12'h124, 50, 10, 1, 7, 3, 5, 64'h800, 0);
      run_job("R5 zero width", 12'h122, 0, 10, 4, 0, 1, 1, 64'h100, 0);
      run_job("R10 wrap", 12'h456, 4000, 900, 16, 3999, 899, 300, 64'hFF_FFFF_FF00, 0);
      run_job("R10 low carry", 12'h000, 1024, 64, 4, 100, 3, 0, 64'h00_FFFF_FFF0, 0);
      run_job("R6 max fields", 12'hFFF, 19'h7FFFF, 13'h1FFF, 31, 19'h7FFFF, 13'h1FFF,
              12'hFFF, 64'hAB_CDEF_0123, 0);
      run_job("R8 start while busy", 12'h235, 640, 480, 4, 123, 45, 13, 64'h55_0000_0000, 1);

      seed = 32'h1234_5678;
      for (int k = 0; k < 24; k++) begin
         longint unsigned r[8];
         for (int j = 0; j < 8; j++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            r[j] = 64'(seed);
            seed = seed * 32'd1103515245 + 32'd12345;
            r[j] = (r[j] << 16) ^ 64'(seed);
         end
         run_job("R3 sweep", r[0] & 12'hFFF, r[1] & 19'h7FFFF, r[2] & 13'h1FFF,
                 r[3] & 5'h1F, r[4] & 19'h7FFFF, r[5] & 13'h1FFF, r[6] & 12'hFFF,
                 r[7] & M40, (k % 5) == 2);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule